// File: doc/BRIEF.md
# Integer Fixed-Point Logarithm Unit

This unit returns the natural logarithm of a positive fixed-point number and uses only integer operations. Each input is an unsigned integer X with a signed scaling count Q. Together they stand for the real value x = X·2^(-Q). The unit uses the identity ln(x) = ln(X) − Q·ln 2. X is normalised by locating its highest set bit k, which gives X = m·2^k with m in [1,2). That leaves ln(m) + (k − Q)·ln 2.

ln(m) is approximated on u = m − 1 by the third-order series u − u²/2 + u³/3. The series is evaluated in Horner form as u·(1 + u·(−1/2 + u/3)), spread over three multiply stages. The exponent term uses a stored fixed-point ln 2 constant. Every result leaves as a signed 16-bit value in Q11 format, meaning the real result times 2048.

Inputs are taken through a valid/ready handshake and results leave through another. One stall enable moves the whole pipeline forward together. The unit accepts one value per cycle whenever the output is free or being consumed.

Top module: `log_q11_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: For X > 0, out_log is within ±2 LSB of 2048·(u − u²/2 + u³/3 + (k − Q)·ln 2), clamped to the int16 range. Here k is the index of the highest set bit of X, and u is the 15 bits directly below that bit read as a fraction over 2^15 (zero-filled when fewer bits exist).
- R3: When X = 2^Q (the real value 1.0), out_log is exactly 0.
- R4: An input X = 0 returns −32768 (0x8000), whatever Q is.
- R5: Results above 32767 return exactly 32767. Results below −32768 return exactly −32768.
- R6: Without back-pressure, a result is on the outputs after the fifth rising edge, counting the edge that accepted the input as the first.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_log hold their values into the next cycle.
- R8: in_ready is 0 whenever out_valid is 1 and out_ready is 0. It is 1 otherwise.
- R9: Results leave in acceptance order, one per input and none extra. With out_ready held at 1, an input is accepted every cycle.
- R10: in_q is a 6-bit two's-complement count. A negative value scales X up by 2^(−Q).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_x | input | IN_W (32) | Unsigned integer X |
| in_q | input | Q_W (6) | Signed scaling count Q (two's complement) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_log | output | 16 | ln(X·2^(−Q)) as int16 Q11 |

## Verification
With no back-pressure, every result is due at the fifth rising edge after its acceptance edge. The driver stamps each expected item with the cycle in which it was offered. The monitor samples on the falling edge and requires the result to appear exactly five cycles after that stamp. In phases where out_ready toggles, latency is not fixed, so the monitor checks order, value, hold-while-stalled and the blocked in_ready on every stalled cycle. A phase changes only after the scoreboard queue has drained, so no timed item carries a stall from an earlier phase.

// File: rtl/log_pkg.sv
package log_pkg;
  // ln(2) held in Q16; narrower formats are rounded from it
  localparam int LN2_Q16 = 45426;
  localparam int OUT_W   = 16;
  localparam int LAT     = 5;

  function automatic int ln2_fixed(input int frac);
    return (LN2_Q16 + (1 << (15 - frac))) >>> (16 - frac);
  endfunction

  function automatic int third_fixed(input int frac);
    return ((1 << frac) + 1) / 3;
  endfunction
endpackage

// File: rtl/msb_locate.sv
module msb_locate #(
  parameter int W   = 32,
  parameter int P_W = $clog2(W)
) (
  input  logic [W-1:0]   val,
  output logic [P_W-1:0] pos,
  output logic           is_zero
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) pos = P_W'(i);
    end
    is_zero = (val == '0);
  end
endmodule

// File: rtl/horner_mac_stage.sv
module horner_mac_stage #(
  parameter int FRAC  = 15,
  parameter int ACC_W = 18,
  parameter int E_W   = 8,
  parameter int KADD  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_v,
  input  logic [FRAC-1:0]         in_u,
  input  logic signed [ACC_W-1:0] in_acc,
  input  logic signed [E_W-1:0]   in_e,
  input  logic                    in_z,
  output logic                    out_v,
  output logic [FRAC-1:0]         out_u,
  output logic signed [ACC_W-1:0] out_acc,
  output logic signed [E_W-1:0]   out_e,
  output logic                    out_z
);
  localparam int PW = FRAC + 1 + ACC_W;

  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    sum;
  logic signed [ACC_W-1:0] acc_n;
  logic                    v_n;

  // acc_next = (u * acc) >> FRAC + KADD
  always_comb begin
    prod  = PW'($signed({1'b0, in_u})) * PW'(in_acc);
    sum   = (prod >>> FRAC) + PW'(KADD);
    acc_n = ACC_W'(sum);
    v_n   = en ? in_v : out_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_v <= 1'b0;
    else        out_v <= v_n;
  end

  always_ff @(posedge clk) begin
    if (en && in_v) begin
      out_u   <= in_u;
      out_acc <= acc_n;
      out_e   <= in_e;
      out_z   <= in_z;
    end
  end
endmodule

// File: rtl/log_q11_unit.sv
module log_q11_unit
  import log_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int Q_W   = 6,
  parameter int FRAC  = 15,
  parameter int OUT_F = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_x,
  input  logic [Q_W-1:0]   in_q,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_log
);
  localparam int K_W    = $clog2(IN_W);
  localparam int E_W    = ((K_W > Q_W) ? K_W : Q_W) + 2;
  localparam int ACC_W  = FRAC + 3;
  localparam int NW     = IN_W + FRAC;
  localparam int SW     = 32;
  localparam int STAGES = 3;
  localparam int LN2    = ln2_fixed(FRAC);
  localparam int C3     = third_fixed(FRAC);
  localparam int MAXV   = (1 << (OUT_W - 1)) - 1;
  localparam int MINV   = -(1 << (OUT_W - 1));

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 0: normalise
  logic [K_W-1:0]        kpos;
  logic [K_W-1:0]        sh;
  logic                  x_zero;
  logic [NW-1:0]         norm;
  logic [FRAC-1:0]       u0;
  logic signed [E_W-1:0] e0;

  msb_locate #(.W(IN_W), .P_W(K_W)) u_msb (
    .val(in_x), .pos(kpos), .is_zero(x_zero)
  );

  always_comb begin
    sh   = K_W'(IN_W - 1) - kpos;
    norm = {in_x, {FRAC{1'b0}}} << sh;
    u0   = FRAC'(norm >> (IN_W - 1));
    e0   = $signed(E_W'(kpos)) - E_W'($signed(in_q));
  end

  logic                    v_p [0:STAGES];
  logic [FRAC-1:0]         u_p [0:STAGES];
  logic signed [ACC_W-1:0] a_p [0:STAGES];
  logic signed [E_W-1:0]   e_p [0:STAGES];
  logic                    z_p [0:STAGES];
  logic                    v0_n;

  assign v0_n = adv ? in_valid : v_p[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_p[0] <= 1'b0;
    else        v_p[0] <= v0_n;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      u_p[0] <= u0;
      a_p[0] <= ACC_W'(C3);
      e_p[0] <= e0;
      z_p[0] <= x_zero;
    end
  end

  // Horner stages: constants added after each multiply are -1/2, +1, 0
  for (genvar g = 0; g < STAGES; g++) begin : g_mac
    localparam int KADD = (g == 0) ? -(1 << (FRAC - 1)) : ((g == 1) ? (1 << FRAC) : 0);
    horner_mac_stage #(
      .FRAC(FRAC), .ACC_W(ACC_W), .E_W(E_W), .KADD(KADD)
    ) u_stage (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .in_v(v_p[g]), .in_u(u_p[g]), .in_acc(a_p[g]), .in_e(e_p[g]), .in_z(z_p[g]),
      .out_v(v_p[g+1]), .out_u(u_p[g+1]), .out_acc(a_p[g+1]),
      .out_e(e_p[g+1]), .out_z(z_p[g+1])
    );
  end

  // Output: add exponent term, rescale to Q(OUT_F), saturate
  logic signed [SW-1:0]    sum_w;
  logic signed [SW-1:0]    scaled;
  logic signed [OUT_W-1:0] res_n;
  logic                    ov_n;

  always_comb begin
    sum_w  = SW'(a_p[STAGES]) + SW'(e_p[STAGES]) * SW'(LN2);
    scaled = sum_w >>> (FRAC - OUT_F);
    if (z_p[STAGES])                res_n = OUT_W'(MINV);
    else if (scaled > SW'(MAXV))    res_n = OUT_W'(MAXV);
    else if (scaled < SW'(MINV))    res_n = OUT_W'(MINV);
    else                            res_n = OUT_W'(scaled);
    ov_n = adv ? v_p[STAGES] : out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= ov_n;
  end

  always_ff @(posedge clk) begin
    if (adv && v_p[STAGES]) out_log <= res_n;
  end
endmodule

// File: rtl/log_q11_unit_chk.sv
module log_q11_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_log
);
  logic [3:0] inflight;
  logic       acc, del;
  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 4'(acc) - 4'(del);
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_log)); // R7
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_IN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R8
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'd5); // R9
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 4'd0); // R9
endmodule

bind log_q11_unit log_q11_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_log(out_log)
);

// File: tb/log_q11_unit_tb.sv
module log_q11_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_x;
  logic [5:0]  in_q;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_log;

  always #10 clk = ~clk; // 50 MHz

  log_q11_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_log(out_log)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  bit stall_prev = 1'b0;
  logic [15:0] held;
  logic [15:0] lfsr = 16'hACE1;

  int q_exp[$];
  int q_tol[$];
  int q_req[$];
  int q_cyc[$];
  bit q_lat[$];

  always @(posedge clk) cyc <= cyc + 1;

  // consumer ready pattern, changed away from both edges
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    end
  end

  // reference from the requirements (R2..R5, R10)
  function automatic void model(input logic [31:0] x, input int q, output int e, output int t);
    int k;
    logic [31:0] sh;
    int fr;
    real ur, r;
    if (x == 0) begin e = -32768; t = 0; return; end // R4
    k = 0;
    for (int i = 0; i < 32; i++) if (x[i]) k = i;
    sh = x << (31 - k);
    fr = int'((sh >> 16) & 32'h7FFF);
    ur = fr / 32768.0;
    r  = (ur - ur*ur/2.0 + ur*ur*ur/3.0 + (k - q) * 0.6931471805599453) * 2048.0;
    if (r >= 32769.0)       begin e = 32767;  t = 0; end  // R5
    else if (r <= -32770.0) begin e = -32768; t = 0; end  // R5
    else begin
      e = int'(r);
      if (e > 32767) e = 32767;
      if (e < -32768) e = -32768;
      t = (fr == 0 && k == q) ? 0 : 2; // R3 exact, else R2 tolerance
    end
  endfunction

  task automatic fail(input int req, input int act, input int exp);
    errors++;
    $display("FAIL R%0d: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
  endtask

  task automatic send(input logic [31:0] x, input int q, input int req);
    int e, t;
    model(x, q, e, t);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = x;
    in_q = q[5:0];
    while (!in_ready) @(negedge clk);
    q_exp.push_back(e);
    q_tol.push_back(t);
    q_req.push_back(req);
    q_cyc.push_back(cyc);
    q_lat.push_back(!bp_mode);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (q_exp.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) fail(8, 1, 0); // R8
        if (stall_prev) begin
          checks++;
          if (out_log !== held) fail(7, int'($signed(out_log)), int'($signed(held))); // R7
        end
      end
      stall_prev = out_valid && !out_ready;
      held = out_log;
      if (out_valid && out_ready) begin
        checks++;
        if (q_exp.size() == 0) fail(9, int'($signed(out_log)), 0); // R9 extra result
        else begin
          int e, t, rq, c, d;
          bit l;
          e = q_exp.pop_front(); t = q_tol.pop_front(); rq = q_req.pop_front();
          c = q_cyc.pop_front(); l = q_lat.pop_front();
          d = int'($signed(out_log)) - e;
          if (d > t || d < -t) fail(rq, int'($signed(out_log)), e);
          if (l) begin
            checks++;
            if (cyc - c != 5) fail(6, cyc - c, 5); // R6 latency
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9: watchdog, actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_q = '0;
    repeat (3) @(negedge clk);
    checks++; if (out_valid !== 1'b0) fail(1, int'(out_valid), 0); // R1
    checks++; if (in_ready !== 1'b1) fail(1, int'(in_ready), 1);   // R1
    rst_n = 1'b1;
    @(negedge clk);
    checks++; if (out_valid !== 1'b0) fail(1, int'(out_valid), 0); // R1
    checks++; if (in_ready !== 1'b1) fail(1, int'(in_ready), 1);   // R1

    // R3: value 1.0 gives exactly 0
    send(32'd1, 0, 3);
    send(32'd2048, 11, 3);
    send(32'h0010_0000, 20, 3);
    // R2: general values
    send(32'd3, 0, 2);
    send(32'd1000, 0, 2);
    send(32'hDEAD_BEEF, 16, 2);
    send(32'd12345, 8, 2);
    send(32'hFFFF_FFFF, 31, 2);
    // R4: zero input
    send(32'd0, 0, 4);
    send(32'd0, 5, 4);
    // R5: saturation both ways
    send(32'h8000_0000, -32, 5);
    send(32'd1, 31, 5);
    // R10: negative scaling
    send(32'd5, -3, 10);
    send(32'd1, -20, 10);
    drain();

    // R7, R8, R9 under back-pressure
    bp_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] x;
      x = (32'h9E37_79B9 * (i + 1)) ^ (32'h85EB_CA6B >> (i % 7));
      if (i % 5 == 0) x = x >> 20;
      send(x, (i % 24) - 4, 9);
    end
    drain();

    // R9: back-to-back, one per cycle, timed (R6)
    bp_mode = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 12; i++) send(32'd7 + 32'd1013 * i, i - 2, 9);
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule